// File: doc/BRIEF.md
# Buffered-Duty PWM Generator

This block produces a single pulse-width-modulated waveform from an 8-bit up-counter. The counter climbs from zero to a programmable period limit and then starts again from zero, so one PWM period lasts the limit plus one clock cycles. A duty value is compared against the counter. A two-bit waveform mode either detaches the pin or chooses the polarity. The pin then changes level once at the duty match and once when the count restarts at zero.

Software reaches the block through a small word-addressed register port: the duty value, the period limit, the waveform mode and a sticky wrap flag. Duty writes never change the running comparison at once. They land in a holding register that is moved into the live comparator only on the cycle the counter sits at its limit, so no period ever carries a truncated or stretched pulse. Reading the duty address always returns the latest value written, even before it has been applied. The period limit is written straight through. One cycle after the counter sits at its limit, a delayed strobe sets the wrap flag, and the flag stays set until software clears it.

Top module: `bufpwm_top`

## Requirements
- R1: After reset the counter, the duty holding register, the live duty value, the wrap flag and the pin are all zero, the waveform mode is 00 and the period limit reads 0xFF.
- R2: The counter advances by one every clock cycle and returns to zero on the cycle after it equals the period limit, so a period is limit+1 cycles long.
- R3: In waveform modes 00 and 01 the output enable `pwm_oe` is low and `pwm_out` is low on the cycle after the mode register holds such a value.
- R4: In mode 10, `pwm_out` goes low on the clock edge that ends a cycle where the counter equals the live duty value, and goes high on the edge that ends a cycle where the counter is zero.
- R5: In mode 11, `pwm_out` goes high on the edge that ends a duty-match cycle and goes low on the edge that ends a zero-count cycle.
- R6: When the live duty value is zero, so that the match and the zero count fall on the same cycle, the match action wins: mode 10 holds the pin low and mode 11 holds it high.
- R7: A write to address 0 updates only the holding register. The live duty value takes the holding value on the edge that ends a cycle where the counter equals the limit, and a read of address 0 returns the holding register.
- R8: The wrap flag becomes 1 two clock edges after the start of a cycle where the counter equals the limit (one cycle of delay after the match), and it stays set without further events.
- R9: Writing address 3 with bit 0 = 1 clears the flag. Writing bit 0 = 0 leaves it unchanged. If a set and a clear arrive on the same edge, the set wins.
- R10: A write to address 1 changes the period limit on the next edge, without buffering. If the new limit is below the current count, the counter keeps counting up through 0xFF and wraps to zero.
- R11: Register map: address 0 is the duty value, address 1 the period limit, address 2 the waveform mode in bits [1:0], and address 3 the wrap flag in bit 0. `reg_rdata` follows `reg_addr` combinationally, and unused read bits are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| pwm_out | output | 1 | PWM waveform, low when detached |
| pwm_oe | output | 1 | High when the mode connects the pin |
| ovf_flag | output | 1 | Sticky wrap flag |

## Verification
The in-RTL assertions check the per-cycle rules on every clock:
- the counter steps by one, and wraps after the limit;
- the live duty value loads only at the limit and holds otherwise;
- the pin is low in the detached modes, and the match action takes priority;
- the flag follows the delayed wrap strobe, and it clears when software writes a 1.

Other behaviour shows only across the bench's scenarios, which compare every output and read value against a behavioural model on every clock:
- the full period length;
- the absence of a glitch when the duty changes in the middle of a period;
- reads returning a value that is still pending;
- duty values above the limit;
- a period limit shrunk below the running count.

// File: rtl/bufpwm_pkg.sv
package bufpwm_pkg;
  localparam int CNT_W = 8;

  typedef enum logic [1:0] {
    A_DUTY = 2'd0,
    A_TOP  = 2'd1,
    A_MODE = 2'd2,
    A_FLAG = 2'd3
  } bufpwm_addr_e;

  typedef enum logic [1:0] {
    M_OFF_A   = 2'd0,
    M_OFF_B   = 2'd1,
    M_LOW_HIT = 2'd2,
    M_HIGH_HIT = 2'd3
  } bufpwm_mode_e;

  function automatic logic [CNT_W-1:0] count_after(input logic [CNT_W-1:0] cur,
                                                   input logic wrap);
    return wrap ? '0 : cur + 1'b1;
  endfunction

  function automatic logic mode_drives(input bufpwm_mode_e m);
    return m[1];
  endfunction

  function automatic logic level_after(input bufpwm_mode_e m, input logic hit,
                                       input logic at_zero, input logic cur);
    if (!mode_drives(m)) return 1'b0;
    if (hit)     return (m == M_HIGH_HIT);
    if (at_zero) return (m == M_LOW_HIT);
    return cur;
  endfunction
endpackage

// File: rtl/bufpwm_counter.sv
module bufpwm_counter
  import bufpwm_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] limit,
  output logic [W-1:0] count,
  output logic         at_limit
);
  assign at_limit = (count == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_after(count, at_limit);
  end

  assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    at_limit |=> (count == '0));
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !at_limit |=> (count == W'($past(count) + 1'b1)));
endmodule

// File: rtl/bufpwm_regs.sv
module bufpwm_regs
  import bufpwm_pkg::*;
#(
  parameter int W = CNT_W,
  parameter logic [W-1:0] LIMIT_RST = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  input  logic         at_limit,
  output logic [W-1:0] rdata,
  output logic [W-1:0] limit_q,
  output bufpwm_mode_e mode_q,
  output logic [W-1:0] duty_live,
  output logic         flag_q
);
  logic [W-1:0] duty_hold;
  logic         wrap_strobe;
  logic         clr_req;
  bufpwm_addr_e a;

  assign a       = bufpwm_addr_e'(addr);
  assign clr_req = we && (a == A_FLAG) && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_hold <= '0;
      limit_q   <= LIMIT_RST;
      mode_q    <= M_OFF_A;
    end else if (we) begin
      case (a)
        A_DUTY:  duty_hold <= wdata;
        A_TOP:   limit_q   <= wdata;
        A_MODE:  mode_q    <= bufpwm_mode_e'(wdata[1:0]);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        duty_live <= '0;
    else if (at_limit) duty_live <= duty_hold;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrap_strobe <= 1'b0;
      flag_q      <= 1'b0;
    end else begin
      wrap_strobe <= at_limit;
      if (wrap_strobe)  flag_q <= 1'b1;
      else if (clr_req) flag_q <= 1'b0;
    end
  end

  always_comb begin
    case (a)
      A_DUTY:  rdata = duty_hold;
      A_TOP:   rdata = limit_q;
      A_MODE:  rdata = W'(mode_q);
      default: rdata = W'(flag_q);
    endcase
  end

  assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    at_limit |=> (duty_live == $past(duty_hold)));
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !at_limit |=> $stable(duty_live));
  assert_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_strobe |=> flag_q);
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !wrap_strobe) |=> !flag_q);
endmodule

// File: rtl/bufpwm_wave.sv
module bufpwm_wave
  import bufpwm_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  bufpwm_mode_e mode,
  input  logic [W-1:0] count,
  input  logic [W-1:0] duty_live,
  output logic         pin,
  output logic         pin_oe
);
  logic hit_evt;
  logic zero_evt;

  assign hit_evt  = (count == duty_live);
  assign zero_evt = (count == '0);
  assign pin_oe   = mode_drives(mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin <= 1'b0;
    else        pin <= level_after(mode, hit_evt, zero_evt, pin);
  end

  assert_detached_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mode[1] |=> !pin);
  assert_low_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_LOW_HIT && hit_evt) |=> !pin);
  assert_high_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_HIGH_HIT && hit_evt) |=> pin);
  assert_zero_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_LOW_HIT && zero_evt && !hit_evt) |=> pin);
endmodule

// File: rtl/bufpwm_top.sv
module bufpwm_top
  import bufpwm_pkg::*;
#(
  parameter int W = CNT_W,
  parameter logic [W-1:0] LIMIT_RST = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_we,
  input  logic [1:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  output logic         pwm_out,
  output logic         pwm_oe,
  output logic         ovf_flag
);
  logic [W-1:0] limit_q;
  logic [W-1:0] count;
  logic [W-1:0] duty_live;
  logic         at_limit;
  bufpwm_mode_e mode_q;

  bufpwm_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .limit(limit_q),
    .count(count), .at_limit(at_limit)
  );

  bufpwm_regs #(.W(W), .LIMIT_RST(LIMIT_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .at_limit(at_limit), .rdata(reg_rdata),
    .limit_q(limit_q), .mode_q(mode_q), .duty_live(duty_live),
    .flag_q(ovf_flag)
  );

  bufpwm_wave #(.W(W)) u_wave (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .count(count),
    .duty_live(duty_live), .pin(pwm_out), .pin_oe(pwm_oe)
  );

  assert_oe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm_oe && $stable(pwm_oe)) |-> !pwm_out);
endmodule

// File: tb/tb_bufpwm_top.sv
`timescale 1ns/1ps
module tb_bufpwm_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       pwm_out, pwm_oe, ovf_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_cnt, m_hold, m_live, m_top, m_mode, m_pin, m_flag;
  int m_pend[$];

  always #4 clk = ~clk;

  bufpwm_top dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out),
    .pwm_oe(pwm_oe), .ovf_flag(ovf_flag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_hold = 0; m_live = 0; m_top = 255; m_mode = 0;
      m_pin = 0; m_flag = 0; m_pend = {0};
    end else begin
      int o_cnt, o_hold, o_top, o_mode, strobe;
      bit wrap;
      o_cnt = m_cnt; o_hold = m_hold; o_top = m_top; o_mode = m_mode;
      wrap = (o_cnt == o_top);
      if (o_mode < 2) m_pin = 0;
      else if (o_cnt == m_live) m_pin = (o_mode == 3) ? 1 : 0;
      else if (o_cnt == 0) m_pin = (o_mode == 2) ? 1 : 0;
      strobe = m_pend.pop_front();
      m_pend.push_back(wrap ? 1 : 0);
      if (strobe == 1) m_flag = 1;
      else if (reg_we && reg_addr == 2'd3 && reg_wdata[0]) m_flag = 0;
      if (reg_we) begin
        case (reg_addr)
          2'd0: m_hold = reg_wdata;
          2'd1: m_top  = reg_wdata;
          2'd2: m_mode = reg_wdata[1:0];
          default: ;
        endcase
      end
      if (wrap) m_live = o_hold;
      m_cnt = wrap ? 0 : (o_cnt + 1) % 256;
    end
  end

  function automatic int model_read(input logic [1:0] a);
    case (a)
      2'd0: return m_hold;
      2'd1: return m_top;
      2'd2: return m_mode;
      default: return m_flag;
    endcase
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      string pr;
      pr = (m_mode < 2) ? "R3" : (m_live == 0 ? "R6" : (m_mode == 2 ? "R4" : "R5"));
      check(pwm_out == m_pin[0], {pr, "/", cur_req, " pwm_out"}, pwm_out, m_pin);
      check(pwm_oe == (m_mode >= 2), {"R3/", cur_req, " pwm_oe"}, pwm_oe, m_mode >= 2);
      check(ovf_flag == m_flag[0], {"R8/R9/", cur_req, " ovf_flag"}, ovf_flag, m_flag);
      check(int'(reg_rdata) == model_read(reg_addr),
            {(reg_addr == 0) ? "R7" : "R11", "/", cur_req, " reg_rdata"},
            reg_rdata, model_read(reg_addr));
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic rd_check(input logic [1:0] a, input int exp, input string req);
    @(negedge clk); #1;
    reg_addr = a;
    @(negedge clk);
    check(int'(reg_rdata) == exp, req, reg_rdata, exp);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int period;
    idle(3);
    rst_n = 1'b1;
    // R1 reset state, R11 map
    cur_req = "R1";
    check(pwm_out == 1'b0, "R1 pwm_out", pwm_out, 0);
    check(ovf_flag == 1'b0, "R1 ovf_flag", ovf_flag, 0);
    rd_check(2'd0, 0, "R1 duty");
    rd_check(2'd1, 255, "R1 limit");
    rd_check(2'd2, 0, "R1 mode");
    cur_req = "R11";
    wr(2'd2, 8'hFE);
    rd_check(2'd2, 2, "R11 mode bits");
    wr(2'd2, 8'h00);

    // R10 immediate limit write, R4 mode 10
    cur_req = "R10";
    wr(2'd1, 8'h1F);
    rd_check(2'd1, 8'h1F, "R10 limit write");
    idle(300);
    cur_req = "R4";
    wr(2'd0, 8'h08);
    wr(2'd2, 8'h02);
    idle(80);
    // R2 period length
    cur_req = "R2";
    while (pwm_out !== 1'b0) @(negedge clk);
    while (pwm_out !== 1'b1) @(negedge clk);
    period = 0;
    do begin @(negedge clk); period++; end while (pwm_out !== 1'b1 || period < 2);
    while (pwm_out !== 1'b0) begin @(negedge clk); period++; end
    while (pwm_out !== 1'b1) begin @(negedge clk); period++; end
    check(period == 32, "R2 period", period, 32);
    #1;

    // R7 duty change mid-period, read-back pending
    cur_req = "R7";
    idle(11);
    wr(2'd0, 8'h14);
    rd_check(2'd0, 8'h14, "R7 pending read");
    idle(70);

    cur_req = "R5";
    wr(2'd2, 8'h03);
    idle(70);

    cur_req = "R6";
    wr(2'd0, 8'h00);
    idle(70);
    check(pwm_out == 1'b1, "R6 mode 11 duty 0", pwm_out, 1);
    wr(2'd2, 8'h02);
    idle(70);
    check(pwm_out == 1'b0, "R6 mode 10 duty 0", pwm_out, 0);

    cur_req = "R4";
    wr(2'd0, 8'h30);
    idle(80);
    check(pwm_out == 1'b1, "R4 duty above limit", pwm_out, 1);

    // R8/R9 flag behaviour
    cur_req = "R9";
    while (ovf_flag !== 1'b1) @(negedge clk);
    #1;
    wr(2'd3, 8'h00);
    check(ovf_flag == 1'b1, "R9 write 0 ignored", ovf_flag, 1);
    wr(2'd3, 8'h01);
    check(ovf_flag == 1'b0, "R9 write 1 clears", ovf_flag, 0);
    cur_req = "R8";
    idle(40);
    check(ovf_flag == 1'b1, "R8 flag set again", ovf_flag, 1);

    // R10 limit shrunk below running count
    cur_req = "R10";
    wr(2'd1, 8'hFF);
    wr(2'd0, 8'h40);
    idle(200);
    wr(2'd1, 8'h10);
    idle(400);

    cur_req = "R3";
    wr(2'd2, 8'h01);
    idle(50);
    check(pwm_oe == 1'b0 && pwm_out == 1'b0, "R3 mode 01", {pwm_oe, pwm_out}, 0);
    wr(2'd2, 8'h00);
    idle(50);
    check(pwm_oe == 1'b0 && pwm_out == 1'b0, "R3 mode 00", {pwm_oe, pwm_out}, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule